// File: doc/BRIEF.md
# SMT Thread Congestion Throttle

A two-thread core shares its issue queues, its load-miss tracking and its completion table between both hardware threads. This block watches two congestion indicators for each thread. The first is the number of outstanding L2 load misses, which the block counts itself from allocate and retire event pulses. The second is the completion-table occupancy, which arrives as a count. When a thread uses too much of either resource, the block throttles that thread so the other thread keeps moving.

Throttling escalates through three levels. A freshly congested thread first gets a priority-reduce request. If the same thread stays the throttled one for 16 consecutive cycles, the request becomes a decode inhibit. If the thread is over both limits at once, it gets a one-cycle flush pulse for its undispatched instructions, together with a hold level. The hold stays up until both of the thread's counts fall below their limits. Only one thread is throttled at any time.

The miss limit and the occupancy limit are loaded through a small write port. They reset to 4 misses and 12 of the 20 completion-table entries.

Top module: `smt_throttle`

## Requirements
- R1: While reset is high and on the first output cycle after it, all throttle outputs are 0. Reset loads the miss limit with 4 and the occupancy limit with 12.
- R2: Each thread's miss count rises by one on an allocate pulse and falls by one on a retire pulse. It is unchanged when both pulses or neither are present. It saturates at 63 and at 0.
- R3: A thread is congested when its miss count is at or above the miss limit, or its occupancy is at or above the occupancy limit. Each edge evaluates the miss counts held before that edge and the occupancy inputs present at it. The resulting action appears on the outputs after that edge. A newly throttled thread gets priority-reduce only.
- R4: When the same thread has been the throttled one for 16 consecutive evaluations, priority-reduce is replaced by decode-inhibit. Decode-inhibit stays while that thread remains throttled.
- R5: When the throttled thread is over both limits, its hold output is asserted. Its flush output pulses high for exactly one cycle, on the first cycle of the hold.
- R6: Once held, a thread stays held while either of its counts is at or above its limit, unless the other thread takes over the throttle. The hold ends only when both counts are below their limits.
- R7: At most one thread has any throttle output active. If both threads are congested, the thread with more occupied entries is throttled, and thread 1 wins a tie. A change of throttled thread restarts escalation at priority-reduce.
- R8: A write with cfg_sel=0 loads the miss limit from cfg_wdata, and a write with cfg_sel=1 loads the occupancy limit. The new limit is first used at the edge after the write edge.
- R9: For each thread, at most one of priority-reduce, decode-inhibit and hold is active. With no thread congested, all outputs are 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_inc | input | 2 | Per-thread L2 load-miss allocate pulse (bit n = thread n) |
| miss_dec | input | 2 | Per-thread L2 load-miss retire pulse |
| ct_used0 | input | 5 | Completion-table entries held by thread 0 |
| ct_used1 | input | 5 | Completion-table entries held by thread 1 |
| cfg_we | input | 1 | Limit write strobe |
| cfg_sel | input | 1 | 0 selects the miss limit, 1 selects the occupancy limit |
| cfg_wdata | input | 6 | Limit value to write |
| prio_down | output | 2 | Per-thread priority-reduce request |
| decode_block | output | 2 | Per-thread decode inhibit |
| flush_pulse | output | 2 | Per-thread one-cycle flush request |
| dispatch_hold | output | 2 | Per-thread hold level that follows a flush |

## Verification
Some properties are checked on every cycle. Only one thread is ever throttled, and each thread has at most one action level active. A flush is always a single cycle and always comes with hold. Decode-inhibit only ever follows priority-reduce. A held thread stays held while it remains over a limit and uncontested, and the outputs clear once nothing is congested. The miss counters stay still when allocate and retire pulses balance, and they stick at full scale.

Other behaviours need the bench's scenarios. These are the exact 16-cycle escalation point, the thresholds as boundaries (3 misses against a limit of 4), and the tie rule between threads. They also include the one-cycle delay before a new limit takes effect, the restored defaults after a reset, and counter saturation with no wraparound. These are shown by stimulus sequences checked against the behavioural model.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int THR_W       = 6;
    localparam int CT_ENTRIES  = 20;
    localparam int CT_W        = $clog2(CT_ENTRIES + 1);
    localparam int PERSIST_CYC = 16;
    localparam logic [THR_W-1:0] DEF_MISS_LIM = 6'd4;
    localparam logic [THR_W-1:0] DEF_CT_LIM   = 6'd12;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_PRIO    = 2'd1,
        ACT_INHIBIT = 2'd2,
        ACT_HOLD    = 2'd3
    } act_e;

    typedef struct packed {
        logic valid;
        logic tid;
    } pick_t;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
    import thr_pkg::*;
#(
    parameter int               W        = THR_W,
    parameter logic [W-1:0]     MISS_RST = DEF_MISS_LIM,
    parameter logic [W-1:0]     CT_RST   = DEF_CT_LIM
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] miss_lim,
    output logic [W-1:0] ct_lim
);
    always_ff @(posedge clk) begin
        if (rst) begin
            miss_lim <= MISS_RST;
            ct_lim   <= CT_RST;
        end else if (we) begin
            if (sel) ct_lim   <= wdata;
            else     miss_lim <= wdata;
        end
    end
endmodule

// File: rtl/thr_miss_counter.sv
module thr_miss_counter
    import thr_pkg::*;
#(
    parameter int W = THR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != FULL) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    // R2
    balanced_events_chk: assert property (@(posedge clk) disable iff (rst)
        (inc == dec) |=> $stable(cnt));

    // R2
    saturate_top_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && inc && !dec) |=> (cnt == FULL));
endmodule

// File: rtl/thr_arbiter.sv
module thr_arbiter
    import thr_pkg::*;
#(
    parameter int W       = THR_W,
    parameter int PERSIST = PERSIST_CYC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   over_miss,
    input  logic [1:0]   over_ct,
    input  logic [W-1:0] ct0,
    input  logic [W-1:0] ct1,
    output logic [1:0]   prio_down,
    output logic [1:0]   decode_block,
    output logic [1:0]   flush_pulse,
    output logic [1:0]   dispatch_hold
);
    localparam int AGE_W = $clog2(PERSIST + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(PERSIST);

    logic [1:0]       cong;
    pick_t            pick;
    logic             same_tid;
    logic             hold_cont;
    logic             hold_d;
    logic             flush_d;
    logic [AGE_W-1:0] age_q, age_d;
    act_e             act_d, act_q;
    logic             tid_q;
    logic             flush_q;

    assign cong = over_miss | over_ct;

    // Choice of the thread to throttle: heavier completion-table user, tie to thread 1
    always_comb begin
        pick = '0;
        if (cong[0] && cong[1]) begin
            pick.valid = 1'b1;
            pick.tid   = (ct0 > ct1) ? 1'b0 : 1'b1;
        end else if (cong[0]) begin
            pick.valid = 1'b1;
            pick.tid   = 1'b0;
        end else if (cong[1]) begin
            pick.valid = 1'b1;
            pick.tid   = 1'b1;
        end
    end

    assign same_tid  = pick.valid && (act_q != ACT_NONE) && (tid_q == pick.tid);
    assign hold_cont = same_tid && (act_q == ACT_HOLD);
    assign hold_d    = pick.valid &&
                       ((over_miss[pick.tid] && over_ct[pick.tid]) || hold_cont);
    assign flush_d   = hold_d && !hold_cont;

    always_comb begin
        if (!pick.valid)          age_d = '0;
        else if (!same_tid)       age_d = AGE_W'(1);
        else if (age_q >= AGE_MAX) age_d = AGE_MAX;
        else                      age_d = age_q + 1'b1;
    end

    always_comb begin
        if (hold_d)                act_d = ACT_HOLD;
        else if (age_d >= AGE_MAX) act_d = ACT_INHIBIT;
        else if (pick.valid)       act_d = ACT_PRIO;
        else                       act_d = ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= ACT_NONE;
            tid_q   <= 1'b0;
            flush_q <= 1'b0;
            age_q   <= '0;
        end else begin
            act_q   <= act_d;
            tid_q   <= pick.tid;
            flush_q <= flush_d;
            age_q   <= age_d;
        end
    end

    // Per-thread output decode from the registered action
    for (genvar t = 0; t < 2; t++) begin : g_out
        logic mine;
        assign mine             = (tid_q == 1'(t));
        assign prio_down[t]     = mine && (act_q == ACT_PRIO);
        assign decode_block[t]  = mine && (act_q == ACT_INHIBIT);
        assign dispatch_hold[t] = mine && (act_q == ACT_HOLD);
        assign flush_pulse[t]   = mine && flush_q;

        // R5
        flush_single_chk: assert property (@(posedge clk) disable iff (rst)
            flush_pulse[t] |=> !flush_pulse[t]);

        // R5
        flush_with_hold_chk: assert property (@(posedge clk) disable iff (rst)
            flush_pulse[t] |-> dispatch_hold[t]);

        // R9
        one_level_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0({prio_down[t], decode_block[t], dispatch_hold[t]}));

        // R4
        inhibit_after_prio_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(decode_block[t]) |-> $past(prio_down[t]));

        // R6
        hold_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (dispatch_hold[t] && cong[t] && !cong[1-t]) |=> dispatch_hold[t]);
    end

    // R9
    idle_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cong == 2'b00) |=> (prio_down == 2'b00 && decode_block == 2'b00 &&
                             flush_pulse == 2'b00 && dispatch_hold == 2'b00));
endmodule

// File: rtl/smt_throttle.sv
module smt_throttle
    import thr_pkg::*;
#(
    parameter int W       = THR_W,
    parameter int CW      = CT_W,
    parameter int PERSIST = PERSIST_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    miss_inc,
    input  logic [1:0]    miss_dec,
    input  logic [CW-1:0] ct_used0,
    input  logic [CW-1:0] ct_used1,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [W-1:0]  cfg_wdata,
    output logic [1:0]    prio_down,
    output logic [1:0]    decode_block,
    output logic [1:0]    flush_pulse,
    output logic [1:0]    dispatch_hold
);
    logic [W-1:0] miss_lim, ct_lim;
    logic [W-1:0] miss_cnt [2];
    logic [W-1:0] ct_ext   [2];
    logic [1:0]   over_miss, over_ct;

    assign ct_ext[0] = W'(ct_used0);
    assign ct_ext[1] = W'(ct_used1);

    thr_cfg_regs #(.W(W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .miss_lim (miss_lim),
        .ct_lim   (ct_lim)
    );

    for (genvar t = 0; t < 2; t++) begin : g_thr
        thr_miss_counter #(.W(W)) u_miss (
            .clk (clk),
            .rst (rst),
            .inc (miss_inc[t]),
            .dec (miss_dec[t]),
            .cnt (miss_cnt[t])
        );
        assign over_miss[t] = (miss_cnt[t] >= miss_lim);
        assign over_ct[t]   = (ct_ext[t]   >= ct_lim);
    end

    thr_arbiter #(.W(W), .PERSIST(PERSIST)) u_arb (
        .clk           (clk),
        .rst           (rst),
        .over_miss     (over_miss),
        .over_ct       (over_ct),
        .ct0           (ct_ext[0]),
        .ct1           (ct_ext[1]),
        .prio_down     (prio_down),
        .decode_block  (decode_block),
        .flush_pulse   (flush_pulse),
        .dispatch_hold (dispatch_hold)
    );

    // R7
    single_victim_chk: assert property (@(posedge clk) disable iff (rst)
        !((prio_down[0] | decode_block[0] | dispatch_hold[0]) &&
          (prio_down[1] | decode_block[1] | dispatch_hold[1])));
endmodule

// File: tb/smt_throttle_bench.sv
module smt_throttle_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] miss_inc, miss_dec;
    logic [4:0] ct_used0, ct_used1;
    logic       cfg_we, cfg_sel;
    logic [5:0] cfg_wdata;
    logic [1:0] prio_down, decode_block, flush_pulse, dispatch_hold;

    always #4 clk = ~clk;

    smt_throttle u_smt_throttle (
        .clk(clk), .rst(rst), .miss_inc(miss_inc), .miss_dec(miss_dec),
        .ct_used0(ct_used0), .ct_used1(ct_used1), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .prio_down(prio_down),
        .decode_block(decode_block), .flush_pulse(flush_pulse),
        .dispatch_hold(dispatch_hold)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string phase  = "R1";

    // Behavioural reference model
    int       m_cnt [2];
    int       m_mlim, m_clim, m_age, m_psel;
    bit       m_phold;
    bit [1:0] e_prio, e_dec, e_fl, e_hold;

    always @(posedge clk) begin
        int ctv [2];
        bit cg  [2];
        bit both[2];
        int sel;
        bit hc, hd;
        if (rst) begin
            m_cnt[0] = 0; m_cnt[1] = 0;
            m_mlim = 4; m_clim = 12; m_age = 0; m_psel = -1; m_phold = 0;
            e_prio = 0; e_dec = 0; e_fl = 0; e_hold = 0;
        end else begin
            ctv[0] = ct_used0; ctv[1] = ct_used1;
            for (int t = 0; t < 2; t++) begin
                cg[t]   = (m_cnt[t] >= m_mlim) || (ctv[t] >= m_clim);
                both[t] = (m_cnt[t] >= m_mlim) && (ctv[t] >= m_clim);
            end
            if (cg[0] && cg[1]) sel = (ctv[0] > ctv[1]) ? 0 : 1;
            else if (cg[0])     sel = 0;
            else if (cg[1])     sel = 1;
            else                sel = -1;
            if (sel < 0)           m_age = 0;
            else if (sel == m_psel) m_age = (m_age >= 16) ? 16 : m_age + 1;
            else                   m_age = 1;
            hc = (sel >= 0) && m_phold && (m_psel == sel);
            hd = (sel >= 0) && (both[sel] || hc);
            e_prio = 0; e_dec = 0; e_fl = 0; e_hold = 0;
            if (sel >= 0) begin
                if (hd) begin
                    e_hold[sel] = 1'b1;
                    e_fl[sel]   = !hc;
                end else if (m_age >= 16) e_dec[sel]  = 1'b1;
                else                      e_prio[sel] = 1'b1;
            end
            m_phold = hd;
            m_psel  = sel;
            for (int t = 0; t < 2; t++) begin
                if (miss_inc[t] && !miss_dec[t] && m_cnt[t] < 63) m_cnt[t]++;
                if (miss_dec[t] && !miss_inc[t] && m_cnt[t] > 0)  m_cnt[t]--;
            end
            if (cfg_we) begin
                if (cfg_sel) m_clim = cfg_wdata;
                else         m_mlim = cfg_wdata;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if ({prio_down, decode_block, flush_pulse, dispatch_hold} !==
                {e_prio, e_dec, e_fl, e_hold}) begin
                errors++;
                $display("FAIL %s model: got p=%b d=%b f=%b h=%b expected p=%b d=%b f=%b h=%b",
                         phase, prio_down, decode_block, flush_pulse, dispatch_hold,
                         e_prio, e_dec, e_fl, e_hold);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input bit [1:0] p, input bit [1:0] d,
                              input bit [1:0] f, input bit [1:0] h);
        checks++;
        if ({prio_down, decode_block, flush_pulse, dispatch_hold} !== {p, d, f, h}) begin
            errors++;
            $display("FAIL %s: got p=%b d=%b f=%b h=%b expected p=%b d=%b f=%b h=%b",
                     tag, prio_down, decode_block, flush_pulse, dispatch_hold, p, d, f, h);
        end
    endtask

    task automatic write_lim(input bit sel, input int val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 6'(val);
        tick(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; miss_inc = 0; miss_dec = 0; ct_used0 = 0; ct_used1 = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        tick(3);
        expect_out("R1 in reset", 0, 0, 0, 0);
        rst = 1'b0;
        tick(1);
        expect_out("R1 after reset", 0, 0, 0, 0);

        // R3: four misses on thread 0 against the default limit of 4
        phase = "R3";
        for (int i = 0; i < 4; i++) begin miss_inc = 2'b01; tick(1); end
        miss_inc = 2'b00;
        expect_out("R3 three misses below limit", 0, 0, 0, 0);
        tick(1);
        expect_out("R3 reduce at limit", 2'b01, 0, 0, 0);

        // R4: escalation after 16 evaluations
        phase = "R4";
        tick(14);
        expect_out("R4 still reduce at 15", 2'b01, 0, 0, 0);
        tick(1);
        expect_out("R4 inhibit at 16", 0, 2'b01, 0, 0);
        tick(3);
        expect_out("R4 inhibit held", 0, 2'b01, 0, 0);

        // R5: both limits crossed on thread 0
        phase = "R5";
        ct_used0 = 12;
        tick(1);
        expect_out("R5 flush and hold", 0, 0, 2'b01, 2'b01);
        tick(1);
        expect_out("R5 flush single cycle", 0, 0, 0, 2'b01);

        // R6: hold survives a single limit clearing
        phase = "R6";
        miss_dec = 2'b01; tick(1); miss_dec = 2'b00;
        tick(3);
        expect_out("R6 hold with one limit", 0, 0, 0, 2'b01);
        ct_used0 = 11;
        tick(1);
        expect_out("R6 hold released", 0, 0, 0, 0);

        // R7: both threads congested
        phase = "R7";
        ct_used0 = 13; ct_used1 = 15;
        tick(1);
        expect_out("R7 heavier thread 1", 2'b10, 0, 0, 0);
        ct_used0 = 15;
        tick(1);
        expect_out("R7 tie goes to thread 1", 2'b10, 0, 0, 0);
        ct_used0 = 16;
        tick(1);
        expect_out("R7 switch restarts at reduce", 2'b01, 0, 0, 0);
        ct_used0 = 0; ct_used1 = 0;
        tick(1);
        expect_out("R7 all clear", 0, 0, 0, 0);

        // R8: limit writes take effect one edge later
        phase = "R8";
        write_lim(1'b0, 2);
        expect_out("R8 old limit on write edge", 0, 0, 0, 0);
        tick(1);
        expect_out("R8 new miss limit", 2'b01, 0, 0, 0);
        ct_used1 = 5;
        write_lim(1'b1, 5);
        tick(1);
        expect_out("R8 new occupancy limit", 2'b10, 0, 0, 0);
        ct_used1 = 0;
        write_lim(1'b0, 63);
        write_lim(1'b1, 12);
        tick(2);
        expect_out("R8 limits raised", 0, 0, 0, 0);

        // R2: saturation on thread 1
        phase = "R2";
        miss_inc = 2'b10;
        tick(70);
        miss_inc = 2'b00;
        tick(1);
        expect_out("R2 saturated count at 63", 2'b10, 0, 0, 0);
        miss_inc = 2'b10; miss_dec = 2'b10;
        tick(1);
        miss_inc = 2'b00;
        tick(1);
        miss_dec = 2'b00;
        tick(2);
        expect_out("R2 one retire drops below 63", 0, 0, 0, 0);

        // R1: reset restores default limits
        phase = "R1";
        rst = 1'b1;
        tick(2);
        expect_out("R1 mid-run reset", 0, 0, 0, 0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin miss_inc = 2'b01; tick(1); end
        miss_inc = 2'b00;
        tick(1);
        expect_out("R1 default miss limit", 2'b01, 0, 0, 0);

        // R9: idle clears
        phase = "R9";
        miss_dec = 2'b01;
        tick(4);
        miss_dec = 2'b00;
        tick(2);
        expect_out("R9 idle outputs zero", 0, 0, 0, 0);

        tick(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule